// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers event pulses from thirty peripheral sources and decides which pending request, if any, is offered to the processor core. Every source owns a sticky pending flag, an enable bit and a three-bit priority. Software sets and inspects all of these through a small word-wide register port, together with a control word, the current CPU priority level and a timed masking window.

The controller offers a request when a source is pending, enabled and ranked strictly above the CPU level. It reports the winning source index, which the core uses to locate the vector, and the winning priority. When the core acknowledges, the CPU level is raised to the winner's priority and the previous level is saved on a small stack. A return input restores it, so that handlers can nest. A no-nesting mode stops any new request while a handler runs and locks the level register against software. A disable window, loaded with an instruction count and counted down by a retire strobe, holds back every source ranked 6 or below. Priority 7 still gets through during the window.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A pulse on `src_evt[i]` sets the pending flag of source i whether or not it is enabled. The flag stays set until software writes it. Pending flags are at addresses 0 and 1, with source i at bit i%16 of word i/16. A write stores the written bit, and an event in the same cycle wins.
- R2: Enable bits use the same layout at addresses 2 and 3. Priorities are at addresses 4 to 11: source i uses bits [4*(i%4)+2 : 4*(i%4)] of word 4+i/4. Every register read returns the live contents in the same cycle.
- R3: A source whose priority is 0 is never presented, even when it is pending and enabled.
- R4: `irq_req` is high only when some source is pending, enabled and has a priority strictly greater than the 4-bit CPU level. The CPU level is at address 13, bits [3:0]. `irq_lvl` gives the winner's priority.
- R5: Among the eligible sources the highest priority wins. When priorities are equal the lowest index wins. `irq_vec` carries the winning index.
- R6: `irq_ack` while `irq_req` is high sets the CPU level to `irq_lvl`, saves the old level and sets the in-service bit (control word, address 12, bit 2). `irq_ret` restores the most recently saved level, and the in-service bit clears once no saved level remains.
- R7: While the no-nesting bit (address 12, bit 0) is set and a handler is in service, `irq_req` stays low whatever the priority of the pending source.
- R8: While the no-nesting bit is set, software writes to the CPU level register are ignored.
- R9: A write to address 14 loads the disable count from bits [13:0]. While the count is nonzero, the window bit (address 12, bit 1) reads 1, sources of priority 1 to 6 are held back and priority 7 sources still pass.
- R10: Each `instr_retire` pulse decrements a nonzero count, and the window bit clears at the same edge where the count reaches zero. The remaining count reads back at address 14.
- R11: After reset all flags, enables, priorities, the CPU level, the control bits and the count are zero, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 30 | Event pulses from the sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| instr_retire | input | 1 | One pulse per retired instruction |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_ret | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | A request is offered |
| irq_vec | output | 6 | Index of the winning source |
| irq_lvl | output | 3 | Priority of the winning source |

## Verification
The bench goes after the ranking corners. Two sources share the top priority, and if the tie is broken toward the higher index the wrong vector comes out. A level equal to a source's priority must mask it, and a design comparing with greater-or-equal would fire. Nesting runs two levels deep and unwinds; a single saved level would return to zero too early. With no-nesting set, a higher-priority event during service must stay hidden, and a level write must not land. In the disable window the count must fall one per retire while the window bit stays set. A priority 7 source must pass and a priority 3 source must not. A window that cleared one retire late or masked level 7 would show up at once.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int PRIO_W = 3;
   localparam int LVL_W  = 4;
   localparam int FIELD_W = 4;
   typedef logic [PRIO_W-1:0] prio_t;
   typedef logic [LVL_W-1:0]  lvl_t;
   localparam prio_t PRIO_NMI_LIKE = prio_t'(7);
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_pkg::*;
#(
   parameter int NUM_SRC   = 30,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int FLAG_BASE = 0,
   parameter int EN_BASE   = 2,
   parameter int PRIO_BASE = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] evt,
   output logic [NUM_SRC-1:0] flag,
   output logic [NUM_SRC-1:0] en,
   output prio_t              prio [NUM_SRC],
   output logic [DATA_W-1:0]  rdata
);
   localparam int SPW = DATA_W / FIELD_W;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int FW = i / DATA_W;
      localparam int FB = i % DATA_W;
      localparam int PW = i / SPW;
      localparam int PB = (i % SPW) * FIELD_W;
      localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_BASE + FW);
      localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_BASE + FW);
      localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(PRIO_BASE + PW);
      logic  f_q, e_q;
      prio_t p_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= 1'b0;
            e_q <= 1'b0;
            p_q <= '0;
         end else begin
            f_q <= ((wr && addr == A_FLAG) ? wdata[FB] : f_q) | evt[i];
            if (wr && addr == A_EN)   e_q <= wdata[FB];
            if (wr && addr == A_PRIO) p_q <= wdata[PB +: PRIO_W];
         end
      end

      assign flag[i] = f_q;
      assign en[i]   = e_q;
      assign prio[i] = p_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (addr == ADDR_W'(FLAG_BASE + i / DATA_W)) rdata[i % DATA_W] = flag[i];
         if (addr == ADDR_W'(EN_BASE + i / DATA_W))   rdata[i % DATA_W] = en[i];
         if (addr == ADDR_W'(PRIO_BASE + i / SPW))
            rdata[(i % SPW) * FIELD_W +: PRIO_W] = prio[i];
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 30,
   parameter int VEC_W   = 6
) (
   input  logic [NUM_SRC-1:0] cand,
   input  prio_t              prio [NUM_SRC],
   output logic               found,
   output logic [VEC_W-1:0]   win_idx,
   output prio_t              win_prio
);
   always_comb begin
      win_prio = '0;
      win_idx  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (cand[i] && prio[i] > win_prio) begin
            win_prio = prio[i];
            win_idx  = VEC_W'(i);
         end
      end
      found = (win_prio != '0);
   end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
   import irq_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push,
   input  lvl_t  push_lvl,
   input  logic  pop,
   input  logic  sw_wr,
   input  lvl_t  sw_lvl,
   output lvl_t  cur_lvl,
   output logic  in_svc
);
   localparam int PTR_W = $clog2(DEPTH + 1);
   lvl_t             stk [DEPTH];
   logic [PTR_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         cur_lvl <= '0;
         for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
      end else if (push) begin
         if (ptr != PTR_W'(DEPTH)) begin
            stk[ptr] <= cur_lvl;
            ptr      <= ptr + 1'b1;
         end
         cur_lvl <= push_lvl;
      end else if (pop && ptr != '0) begin
         cur_lvl <= stk[ptr - 1'b1];
         ptr     <= ptr - 1'b1;
      end else if (sw_wr) begin
         cur_lvl <= sw_lvl;
      end
   end

   assign in_svc = (ptr != '0);
endmodule

// File: rtl/irq_dis_window.sv
module irq_dis_window #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (tick && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
   import irq_pkg::*;
#(
   parameter int NUM_SRC   = 30,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int VEC_W     = 6,
   parameter int CNT_W     = 14,
   parameter int STACK_D   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               instr_retire,
   input  logic               irq_ack,
   input  logic               irq_ret,
   output logic               irq_req,
   output logic [VEC_W-1:0]   irq_vec,
   output logic [PRIO_W-1:0]  irq_lvl
);
   localparam int SPW        = DATA_W / FIELD_W;
   localparam int BIT_WORDS  = (NUM_SRC + DATA_W - 1) / DATA_W;
   localparam int PRIO_WORDS = (NUM_SRC + SPW - 1) / SPW;
   localparam int FLAG_BASE  = 0;
   localparam int EN_BASE    = FLAG_BASE + BIT_WORDS;
   localparam int PRIO_BASE  = EN_BASE + BIT_WORDS;
   localparam int CTRL_A     = PRIO_BASE + PRIO_WORDS;
   localparam int LVL_A      = CTRL_A + 1;
   localparam int DISI_A     = CTRL_A + 2;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_A);
   localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(LVL_A);
   localparam logic [ADDR_W-1:0] A_DISI = ADDR_W'(DISI_A);

   if (DISI_A >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register map does not fit the address width");
   end
   if (NUM_SRC > 63 || NUM_SRC >= (1 << VEC_W)) begin : g_bad_vec
      $error("source count exceeds the vector range");
   end
   if (CNT_W > DATA_W || DATA_W < LVL_W) begin : g_bad_data
      $error("data word too narrow");
   end
   if (STACK_D < 7) begin : g_bad_stack
      $error("level stack must hold seven nested levels");
   end

   logic [NUM_SRC-1:0] flag, en, cand;
   prio_t              prio [NUM_SRC];
   logic [DATA_W-1:0]  bank_rdata;
   logic               nonest;
   lvl_t               cur_lvl;
   logic               in_svc;
   logic [CNT_W-1:0]   dis_cnt;
   logic               dis_on;
   logic               found;
   prio_t              win_prio;
   logic [VEC_W-1:0]   win_idx;
   logic               take;

   irq_src_bank #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .FLAG_BASE(FLAG_BASE), .EN_BASE(EN_BASE), .PRIO_BASE(PRIO_BASE)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .evt(src_evt), .flag(flag), .en(en),
      .prio(prio), .rdata(bank_rdata)
   );

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         cand[i] = flag[i] && en[i]
                && ({1'b0, prio[i]} > cur_lvl)
                && (!dis_on || prio[i] == PRIO_NMI_LIKE);
      end
   end

   irq_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
      .cand(cand), .prio(prio), .found(found),
      .win_idx(win_idx), .win_prio(win_prio)
   );

   assign irq_req = found && !(nonest && in_svc);
   assign irq_vec = win_idx;
   assign irq_lvl = win_prio;
   assign take    = irq_ack && irq_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          nonest <= 1'b0;
      else if (reg_wr && reg_addr == A_CTRL) nonest <= reg_wdata[0];
   end

   irq_level_stack #(.DEPTH(STACK_D)) u_lvl (
      .clk(clk), .rst_n(rst_n),
      .push(take), .push_lvl({1'b0, win_prio}), .pop(irq_ret),
      .sw_wr(reg_wr && reg_addr == A_LVL && !nonest),
      .sw_lvl(reg_wdata[LVL_W-1:0]),
      .cur_lvl(cur_lvl), .in_svc(in_svc)
   );

   irq_dis_window #(.CNT_W(CNT_W)) u_dis (
      .clk(clk), .rst_n(rst_n),
      .load(reg_wr && reg_addr == A_DISI),
      .load_val(reg_wdata[CNT_W-1:0]),
      .tick(instr_retire), .cnt(dis_cnt), .active(dis_on)
   );

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = DATA_W'({in_svc, dis_on, nonest});
         A_LVL:   reg_rdata = DATA_W'(cur_lvl);
         A_DISI:  reg_rdata = DATA_W'(dis_cnt);
         default: reg_rdata = bank_rdata;
      endcase
   end
endmodule

// File: rtl/nested_irq_ctrl_chk.sv
module nested_irq_ctrl_chk #(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 14,
   parameter int LVL_A  = 13,
   parameter int DISI_A = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              irq_ack,
   input logic              irq_ret,
   input logic              irq_req,
   input logic [2:0]        irq_lvl,
   input logic              instr_retire,
   input logic [3:0]        cpu_lvl,
   input logic              in_svc,
   input logic              nonest,
   input logic              dis_on,
   input logic [CNT_W-1:0]  dis_cnt
);
   AST_PRIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_lvl != 3'd0); // R3
   AST_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> {1'b0, irq_lvl} > cpu_lvl); // R4
   AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> (cpu_lvl == {1'b0, $past(irq_lvl)}) && in_svc); // R6
   AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      (nonest && in_svc) |-> !irq_req); // R7
   AST_LVL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (nonest && reg_wr && reg_addr == ADDR_W'(LVL_A) && !(irq_ack && irq_req) && !irq_ret)
      |=> cpu_lvl == $past(cpu_lvl)); // R8
   AST_WINDOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_on && irq_req) |-> irq_lvl == 3'd7); // R9
   AST_WINDOW_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_cnt != '0 && instr_retire && !(reg_wr && reg_addr == ADDR_W'(DISI_A)))
      |=> dis_cnt == $past(dis_cnt) - 1'b1); // R10
endmodule

bind nested_irq_ctrl nested_irq_ctrl_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_A(LVL_A), .DISI_A(DISI_A)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
   .irq_lvl(irq_lvl), .instr_retire(instr_retire), .cpu_lvl(cur_lvl),
   .in_svc(in_svc), .nonest(nonest), .dis_on(dis_on), .dis_cnt(dis_cnt)
);

// File: tb/nested_irq_ctrl_test.sv
module nested_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [29:0] src_evt = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        instr_retire = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;
   logic        irq_req;
   logic [5:0]  irq_vec;
   logic [2:0]  irq_lvl;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   nested_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .instr_retire(instr_retire), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 20000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = int'(reg_rdata);
   endtask

   task automatic pulse(logic [29:0] m);
      @(negedge clk); src_evt = m;
      @(negedge clk); src_evt = '0;
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic ret();
      @(negedge clk); irq_ret = 1'b1;
      @(negedge clk); irq_ret = 1'b0;
   endtask

   task automatic retire(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); instr_retire = 1'b1;
         @(negedge clk); instr_retire = 1'b0;
      end
   endtask

   task automatic set_prio(int s, int p);
      int v;
      rd(4 + s / 4, v);
      v[(s % 4) * 4 +: 3] = 3'(p);
      wr(4 + s / 4, v);
   endtask

   task automatic clr_flag(int s);
      int v;
      rd(s / 16, v);
      v[s % 16] = 1'b0;
      wr(s / 16, v);
   endtask

   task automatic sample_out(output int r, output int v, output int l);
      @(negedge clk);
      #1 r = int'(irq_req); v = int'(irq_vec); l = int'(irq_lvl);
   endtask

   task automatic t_reset();
      int d, r, v, l;
      sample_out(r, v, l);
      chk("R11 req after reset", r, 0);
      rd(0, d);  chk("R11 flags after reset", d, 0);
      rd(13, d); chk("R11 level after reset", d, 0);
      rd(12, d); chk("R11 control after reset", d, 0);
   endtask

   task automatic t_sticky();
      int d, r, v, l;
      pulse(30'(1) << 3);
      rd(0, d); chk("R1 flag set while disabled", d, 16'h0008);
      sample_out(r, v, l); chk("R1 disabled source silent", r, 0);
      repeat (3) @(negedge clk);
      rd(0, d); chk("R1 flag sticky", d, 16'h0008);
      wr(0, 0);
      rd(0, d); chk("R1 flag cleared by write", d, 0);
   endtask

   task automatic t_prio0();
      int d, r, v, l;
      wr(2, 16'h0008);
      pulse(30'(1) << 3);
      sample_out(r, v, l); chk("R3 priority zero not presented", r, 0);
      set_prio(3, 2);
      rd(4, d); chk("R2 priority field readback", d, 16'h2000);
      rd(2, d); chk("R2 enable readback", d, 16'h0008);
   endtask

   task automatic t_threshold();
      int r, v, l;
      sample_out(r, v, l);
      chk("R4 req above level", r, 1);
      chk("R4 vec", v, 3);
      chk("R4 lvl", l, 2);
      wr(13, 2);
      sample_out(r, v, l); chk("R4 equal level masks", r, 0);
      wr(13, 1);
      sample_out(r, v, l); chk("R4 lower level passes", r, 1);
      wr(13, 0);
      clr_flag(3);
      wr(2, 0);
   endtask

   task automatic t_arb();
      int r, v, l;
      set_prio(5, 4); set_prio(20, 4); set_prio(17, 3);
      wr(2, 16'h0020); wr(3, 16'h0012);
      pulse((30'(1) << 5) | (30'(1) << 20) | (30'(1) << 17));
      sample_out(r, v, l);
      chk("R5 tie to lowest index vec", v, 5);
      chk("R5 tie lvl", l, 4);
      clr_flag(5);
      sample_out(r, v, l); chk("R5 next at same prio", v, 20);
      clr_flag(20);
      sample_out(r, v, l);
      chk("R5 lower prio vec", v, 17);
      chk("R5 lower prio lvl", l, 3);
   endtask

   task automatic t_nest();
      int d, r, v, l;
      ack();
      rd(13, d); chk("R6 level raised", d, 3);
      rd(12, d); chk("R6 in-service set", d & 4, 4);
      sample_out(r, v, l); chk("R6 serviced source masked", r, 0);
      pulse(30'(1) << 20);
      sample_out(r, v, l); chk("R6 nested req vec", v, 20);
      ack();
      rd(13, d); chk("R6 nested level", d, 4);
      clr_flag(20);
      ret();
      rd(13, d); chk("R6 first return", d, 3);
      ret();
      rd(13, d); chk("R6 second return", d, 0);
      rd(12, d); chk("R6 in-service cleared", d & 4, 0);
   endtask

   task automatic t_nonest();
      int d, r, v, l;
      wr(12, 1);
      wr(13, 5);
      rd(13, d); chk("R8 level write ignored", d, 0);
      ack();
      rd(13, d); chk("R7 ack under no-nesting", d, 3);
      pulse(30'(1) << 20);
      sample_out(r, v, l); chk("R7 higher prio held", r, 0);
      ret();
      sample_out(r, v, l);
      chk("R7 req after return", r, 1);
      chk("R7 vec after return", v, 20);
      clr_flag(20); clr_flag(17);
      wr(12, 0);
   endtask

   task automatic t_disi();
      int d, r, v, l;
      pulse(30'(1) << 17);
      wr(14, 3);
      rd(12, d); chk("R9 window bit set", d & 2, 2);
      sample_out(r, v, l); chk("R9 prio 3 masked", r, 0);
      retire(2);
      rd(14, d); chk("R10 count after two retires", d, 1);
      rd(12, d); chk("R10 window still set", d & 2, 2);
      set_prio(25, 7);
      wr(3, 16'h0212);
      pulse(30'(1) << 25);
      sample_out(r, v, l);
      chk("R9 prio 7 passes", r, 1);
      chk("R9 prio 7 vec", v, 25);
      chk("R9 prio 7 lvl", l, 7);
      retire(1);
      rd(14, d); chk("R10 count zero", d, 0);
      rd(12, d); chk("R10 window cleared", d & 2, 0);
      clr_flag(25);
      sample_out(r, v, l);
      chk("R10 prio 3 unmasked", r, 1);
      chk("R10 prio 3 vec", v, 17);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sticky();
      t_prio0();
      t_threshold();
      t_arb();
      t_nest();
      t_nonest();
      t_disi();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule